// File: doc/BRIEF.md
# Dual-Bank Packet Transmit Buffer

This block is a ping-pong transmit buffer for one bulk-in endpoint of a USB function. It holds two banks. Each bank is one maximum packet (64 bytes), so the buffer holds 128 bytes in all. A producer streams bytes into the current fill bank. The producer may be the CPU or a DMA engine that follows the `dma_req` level. When the packet is complete, the producer pulses `pkt_commit`. That pulse fixes the byte count as the bank's packet length and moves filling to the other bank. Only from that point can the USB side see the packet.

The USB protocol engine sees the oldest committed packet through `pkt_avail` and `pkt_len`. It streams the bytes out over a valid/ready port, marked by `rd_last`. After the host has acknowledged the transfer, it pulses `sent_ack`, which frees that bank. Packets leave in the order they were committed. A `clr` pulse empties both banks at once.

Back-pressure rules. On the write port, a byte moves only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` drops only while both banks hold unsent packets. On the read port, a byte moves only where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_data` and the read position hold. `rd_valid` never depends on `rd_ready`.

Top module: `txpp_buffer`

## Requirements
- R1: After reset, and in the cycle after a `clr` pulse, the outputs are `empty`=1, `busy`=0, `pkt_avail`=0, `ovf`=0 and `rd_valid`=0, and filling restarts at bank 0 with a count of zero.
- R2: `wr_ready` equals the inverse of `busy`. A byte accepted by the `wr_valid`/`wr_ready` handshake is stored at the next free byte position of the fill bank, in arrival order.
- R3: Once the fill bank already holds 64 bytes, further accepted bytes are discarded. The first such byte sets `ovf`, which stays high until the next accepted commit or a clear.
- R4: An accepted `pkt_commit` latches the fill bank's byte count as its packet length. The count includes a byte accepted in the same cycle and may be zero. In the next cycle filling moves to the other bank and restarts at zero.
- R5: `busy` is high exactly while both banks hold unsent committed packets. While `busy` is high, `pkt_commit` has no effect and no byte is accepted.
- R6: `pkt_avail` is high while the oldest committed packet is unsent, with `pkt_len` giving its length. `rd_valid` is high while bytes of it remain to be read. `rd_data` gives those bytes in write order, and `rd_last` marks the final byte. A zero-length packet shows `pkt_avail`=1, `pkt_len`=0 and `rd_valid`=0.
- R7: `sent_ack` while `pkt_avail` is high frees the oldest packet's bank, and reading restarts at byte 0 of the next packet in commit order. `sent_ack` while nothing is committed has no effect.
- R8: `dma_req` is high whenever a fill bank is free to receive data, that is whenever `busy` is low.
- R9: `clr` takes priority over a write, commit or `sent_ack` in the same cycle; none of them leaves any trace.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_data` and the read position stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Pulse that empties both banks |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte can be accepted |
| wr_data | input | 8 | Write byte |
| pkt_commit | input | 1 | Packet-enable pulse: commit fill bank and swap |
| busy | output | 1 | Both banks hold unsent packets; commit is ignored |
| ovf | output | 1 | Sticky: bytes were dropped past the bank size |
| dma_req | output | 1 | A fill bank is free for data |
| empty | output | 1 | No committed packet is held |
| pkt_avail | output | 1 | Oldest committed packet is ready to send |
| pkt_len | output | 7 | Length of that packet in bytes (0..64) |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | USB side takes the read byte |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Read byte is the packet's final byte |
| sent_ack | input | 1 | Host acknowledged the packet; release its bank |

## Verification
The in-RTL assertions check these properties on every cycle:
- the write count never passes the bank size, and `ovf` rises only from a write made at capacity;
- committed state stays frozen while the buffer is busy and no acknowledge arrives, and a committed length never changes while its bank is held;
- a stalled read holds its position;
- an acknowledge alternates the send bank and rewinds the read position.

Only the bench scenarios can show the following:
- the bytes come out in write order and in commit order;
- zero-length and oversize packets get the right lengths;
- a commit during busy leaves no packet behind;
- a clear wipes a same-cycle commit.

// File: rtl/txpp_pkg.sv
package txpp_pkg;
  // Bank index: with two banks a single bit selects one.
  typedef logic txpp_bank_t;
  localparam int unsigned TXPP_NUM_BANKS = 2;
endpackage

// File: rtl/txpp_wr_ctrl.sv
module txpp_wr_ctrl
  import txpp_pkg::*;
#(
  parameter int unsigned PKT_MAX = 64,
  parameter int unsigned CW      = $clog2(PKT_MAX + 1),
  parameter int unsigned AW      = $clog2(PKT_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_fire,
  input  logic          commit_req,
  input  logic          busy,
  output txpp_bank_t    fill_sel,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          commit_fire,
  output logic [CW-1:0] commit_len,
  output logic          ovf
);
  logic [CW-1:0] wcnt_q;
  txpp_bank_t    fill_q;
  logic          ovf_q;
  logic          at_cap;

  assign at_cap      = (wcnt_q == CW'(PKT_MAX));
  assign wr_en       = wr_fire && !at_cap;
  assign wr_addr     = wcnt_q[AW-1:0];
  assign commit_fire = commit_req && !busy && !clr;
  assign commit_len  = wcnt_q + CW'(wr_en);
  assign fill_sel    = fill_q;
  assign ovf         = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wcnt_q <= '0;
      fill_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (commit_fire) begin
      wcnt_q <= '0;
      fill_q <= ~fill_q;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_en) wcnt_q <= wcnt_q + CW'(1);
      if (wr_fire && at_cap) ovf_q <= 1'b1;
    end
  end

  p_wcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= CW'(PKT_MAX));

  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_q && !(wr_fire && at_cap)) |=> !ovf_q);
endmodule

// File: rtl/txpp_bank_state.sv
module txpp_bank_state
  import txpp_pkg::*;
#(
  parameter int unsigned PKT_MAX = 64,
  parameter int unsigned CW      = $clog2(PKT_MAX + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr,
  input  logic                               commit_fire,
  input  txpp_bank_t                         fill_sel,
  input  logic [CW-1:0]                      commit_len,
  input  logic                               ack_fire,
  input  txpp_bank_t                         send_sel,
  output logic [TXPP_NUM_BANKS-1:0]          committed,
  output logic [TXPP_NUM_BANKS-1:0][CW-1:0]  bank_len,
  output logic                               busy
);
  logic [TXPP_NUM_BANKS-1:0]         com_q;
  logic [TXPP_NUM_BANKS-1:0][CW-1:0] len_q;

  for (genvar b = 0; b < TXPP_NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        com_q[b] <= 1'b0;
        len_q[b] <= '0;
      end else begin
        if (commit_fire && (fill_sel == txpp_bank_t'(b))) begin
          com_q[b] <= 1'b1;
          len_q[b] <= commit_len;
        end else if (ack_fire && (send_sel == txpp_bank_t'(b))) begin
          com_q[b] <= 1'b0;
        end
      end
    end

    p_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (com_q[b] && !clr) |=> $stable(len_q[b]));
  end

  assign committed = com_q;
  assign bank_len  = len_q;
  assign busy      = com_q[fill_sel];

  p_busy_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack_fire && !clr) |=> $stable(com_q));
endmodule

// File: rtl/txpp_rd_ctrl.sv
module txpp_rd_ctrl
  import txpp_pkg::*;
#(
  parameter int unsigned PKT_MAX = 64,
  parameter int unsigned CW      = $clog2(PKT_MAX + 1),
  parameter int unsigned AW      = $clog2(PKT_MAX)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr,
  input  logic [TXPP_NUM_BANKS-1:0]          committed,
  input  logic [TXPP_NUM_BANKS-1:0][CW-1:0]  bank_len,
  input  logic                               rd_ready,
  input  logic                               sent_ack,
  output txpp_bank_t                         send_sel,
  output logic [AW-1:0]                      rd_addr,
  output logic                               ack_fire,
  output logic                               pkt_avail,
  output logic [CW-1:0]                      pkt_len,
  output logic                               rd_valid,
  output logic                               rd_last
);
  txpp_bank_t    send_q;
  logic [CW-1:0] rptr_q;
  logic [CW-1:0] head_len;

  assign head_len  = bank_len[send_q];
  assign pkt_avail = committed[send_q];
  assign pkt_len   = pkt_avail ? head_len : '0;
  assign rd_valid  = pkt_avail && (rptr_q < head_len);
  assign rd_last   = rd_valid && ((rptr_q + CW'(1)) == head_len);
  assign ack_fire  = sent_ack && pkt_avail && !clr;
  assign rd_addr   = rptr_q[AW-1:0];
  assign send_sel  = send_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      send_q <= 1'b0;
      rptr_q <= '0;
    end else if (ack_fire) begin
      send_q <= ~send_q;
      rptr_q <= '0;
    end else if (rd_valid && rd_ready) begin
      rptr_q <= rptr_q + CW'(1);
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !sent_ack && !clr) |=> (rd_valid && $stable(rptr_q)));

  p_ack_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !clr) |=> (rptr_q == '0));

  p_ack_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !clr) |=> (send_q != $past(send_q)));
endmodule

// File: rtl/txpp_store.sv
module txpp_store
  import txpp_pkg::*;
#(
  parameter int unsigned PKT_MAX = 64,
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = $clog2(PKT_MAX)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  txpp_bank_t    wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  txpp_bank_t    rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [TXPP_NUM_BANKS-1:0][DW-1:0] bank_out;

  for (genvar b = 0; b < TXPP_NUM_BANKS; b++) begin : g_mem
    logic [DW-1:0] mem [PKT_MAX];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == txpp_bank_t'(b))) mem[wr_addr] <= wr_data;
    end
    assign bank_out[b] = mem[rd_addr];
  end

  assign rd_data = bank_out[rd_bank];
endmodule

// File: rtl/txpp_buffer.sv
module txpp_buffer
  import txpp_pkg::*;
#(
  parameter int unsigned PKT_MAX = 64,
  parameter int unsigned DW      = 8,
  localparam int unsigned CW     = $clog2(PKT_MAX + 1),
  localparam int unsigned AW     = $clog2(PKT_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          pkt_commit,
  output logic          busy,
  output logic          ovf,
  output logic          dma_req,
  output logic          empty,
  output logic          pkt_avail,
  output logic [CW-1:0] pkt_len,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  input  logic          sent_ack
);
  txpp_bank_t                        fill_sel, send_sel;
  logic                              wr_fire, wr_en, commit_fire, ack_fire;
  logic [AW-1:0]                     wr_addr, rd_addr;
  logic [CW-1:0]                     commit_len;
  logic [TXPP_NUM_BANKS-1:0]         committed;
  logic [TXPP_NUM_BANKS-1:0][CW-1:0] bank_len;

  assign wr_ready = !busy;
  assign dma_req  = !busy;
  assign wr_fire  = wr_valid && wr_ready;
  assign empty    = (committed == '0);

  txpp_wr_ctrl #(.PKT_MAX(PKT_MAX), .CW(CW), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_fire(wr_fire),
    .commit_req(pkt_commit), .busy(busy), .fill_sel(fill_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .commit_fire(commit_fire),
    .commit_len(commit_len), .ovf(ovf)
  );

  txpp_bank_state #(.PKT_MAX(PKT_MAX), .CW(CW)) u_state (
    .clk(clk), .rst_n(rst_n), .clr(clr), .commit_fire(commit_fire),
    .fill_sel(fill_sel), .commit_len(commit_len), .ack_fire(ack_fire),
    .send_sel(send_sel), .committed(committed), .bank_len(bank_len),
    .busy(busy)
  );

  txpp_rd_ctrl #(.PKT_MAX(PKT_MAX), .CW(CW), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .committed(committed),
    .bank_len(bank_len), .rd_ready(rd_ready), .sent_ack(sent_ack),
    .send_sel(send_sel), .rd_addr(rd_addr), .ack_fire(ack_fire),
    .pkt_avail(pkt_avail), .pkt_len(pkt_len), .rd_valid(rd_valid),
    .rd_last(rd_last)
  );

  txpp_store #(.PKT_MAX(PKT_MAX), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(fill_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_bank(send_sel), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  p_full_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sent_ack && !clr) |=> (busy && !wr_ready));
endmodule

// File: tb/txpp_buffer_tb.sv
module txpp_buffer_tb;
  localparam int MAXP = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, wr_valid = 1'b0, pkt_commit = 1'b0, rd_ready = 1'b0, sent_ack = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, busy, ovf, dma_req, empty, pkt_avail, rd_valid, rd_last;
  logic [6:0] pkt_len;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  txpp_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .pkt_commit(pkt_commit), .busy(busy), .ovf(ovf),
    .dma_req(dma_req), .empty(empty), .pkt_avail(pkt_avail), .pkt_len(pkt_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .sent_ack(sent_ack)
  );

  int checks = 0, fails = 0, cyc_n = 0;

  // Reference model built from the requirements.
  logic [7:0] m_mem [2][MAXP];
  int m_len [2];
  int m_npend, m_fill, m_head, m_cnt, m_rptr;
  bit m_ovf;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_npend = 0; m_fill = 0; m_head = 0; m_cnt = 0; m_rptr = 0; m_ovf = 0;
    m_len[0] = 0; m_len[1] = 0;
  endfunction

  function automatic void m_step(bit wv, bit [7:0] wd, bit cm, bit rr, bit ak, bit cl);
    bit full, avail, rv, wacc, dcm, dak;
    int newcnt;
    if (cl) begin m_reset(); return; end
    full  = (m_npend == 2);
    avail = (m_npend > 0);
    rv    = avail && (m_rptr < m_len[m_head]);
    wacc  = wv && !full;
    newcnt = m_cnt;
    if (wacc && m_cnt < MAXP) begin m_mem[m_fill][m_cnt] = wd; newcnt = m_cnt + 1; end
    else if (wacc) m_ovf = 1;
    dcm = cm && !full;
    dak = ak && avail;
    if (dcm) begin
      m_len[m_fill] = newcnt; m_fill ^= 1; newcnt = 0; m_ovf = 0;
    end
    m_cnt = newcnt;
    if (dak) begin m_head ^= 1; m_rptr = 0; end
    else if (rv && rr) m_rptr++;
    m_npend = m_npend + int'(dcm) - int'(dak);
  endfunction

  task automatic check_all();
    bit full, avail, rv;
    full  = (m_npend == 2);
    avail = (m_npend > 0);
    rv    = avail && (m_rptr < m_len[m_head]);
    chk("R2", "wr_ready", int'(wr_ready), int'(!full));
    chk("R5", "busy", int'(busy), int'(full));
    chk("R8", "dma_req", int'(dma_req), int'(!full));
    chk("R1", "empty", int'(empty), int'(m_npend == 0));
    chk("R3", "ovf", int'(ovf), int'(m_ovf));
    chk("R6", "pkt_avail", int'(pkt_avail), int'(avail));
    if (avail) chk("R4", "pkt_len", int'(pkt_len), m_len[m_head]);
    chk("R6", "rd_valid", int'(rd_valid), int'(rv));
    if (rv) begin
      chk("R6", "rd_data", int'(rd_data), int'(m_mem[m_head][m_rptr]));
      chk("R6", "rd_last", int'(rd_last), int'(m_rptr + 1 == m_len[m_head]));
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic cyc(bit wv, bit [7:0] wd, bit cm, bit rr, bit ak, bit cl);
    wr_valid = wv; wr_data = wd; pkt_commit = cm; rd_ready = rr; sent_ack = ak; clr = cl;
    m_step(wv, wd, cm, rr, ak, cl);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; pkt_commit = 0; rd_ready = 0; sent_ack = 0; clr = 0;
    check_all();
  endtask

  task automatic write_pkt(int n, int base);
    for (int i = 0; i < n; i++) cyc(1, 8'(base + i), 0, 0, 0, 0);
  endtask

  task automatic drain_and_ack();
    for (int i = 0; i < 70 && rd_valid; i++) cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all();   // R1 reset state
    chk("R1", "reset pkt_avail", int'(pkt_avail), 0);

    // R2/R4/R6: plain packet, read out, acknowledge (R7)
    write_pkt(5, 8'h10);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R4", "len of 5-byte packet", int'(pkt_len), 5);
    drain_and_ack();
    chk("R7", "empty after ack", int'(empty), 1);

    // R4: byte accepted in the commit cycle belongs to the packet
    write_pkt(2, 8'h40);
    cyc(1, 8'h42, 1, 0, 0, 0);
    chk("R4", "len with same-cycle byte", int'(pkt_len), 3);
    drain_and_ack();

    // R4/R6: zero-length packet
    cyc(0, 0, 1, 0, 0, 0);
    chk("R6", "zero-length avail", int'(pkt_avail), 1);
    chk("R6", "zero-length rd_valid", int'(rd_valid), 0);
    cyc(0, 0, 0, 0, 1, 0);

    // R7: acknowledge with nothing held has no effect
    cyc(0, 0, 0, 0, 1, 0);
    chk("R7", "ignored ack keeps empty", int'(empty), 1);

    // R5: both banks full, further commit ignored, order kept
    write_pkt(3, 8'h60);
    cyc(0, 0, 1, 0, 0, 0);
    write_pkt(4, 8'h70);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R5", "busy with two packets", int'(busy), 1);
    cyc(1, 8'hEE, 1, 0, 0, 0);
    chk("R5", "commit while busy keeps head len", int'(pkt_len), 3);
    // R10: stall holds data
    cyc(0, 0, 0, 0, 0, 0);
    chk("R10", "stalled rd_data", int'(rd_data), 8'h60);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R10", "stalled rd_data second byte", int'(rd_data), 8'h61);
    drain_and_ack();
    chk("R7", "second packet in order", int'(rd_data), 8'h70);
    drain_and_ack();
    chk("R5", "no ghost packet after busy commit", int'(empty), 1);

    // R3: overflow past bank size
    write_pkt(MAXP + 2, 8'h00);
    chk("R3", "ovf after oversize", int'(ovf), 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R3", "length capped", int'(pkt_len), MAXP);
    chk("R3", "ovf cleared by commit", int'(ovf), 0);
    drain_and_ack();

    // R9: clear beats commit, write and ack
    write_pkt(3, 8'h90);
    cyc(0, 0, 1, 0, 0, 0);
    write_pkt(2, 8'hA0);
    cyc(1, 8'hA5, 1, 1, 1, 1);
    chk("R9", "clear wins over commit", int'(empty), 1);
    chk("R1", "clear state pkt_avail", int'(pkt_avail), 0);
    write_pkt(2, 8'hB0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R9", "fill restarted at zero", int'(pkt_len), 2);
    drain_and_ack();

    // Random traffic
    for (int t = 0; t < 6000; t++) begin
      bit wv, cm, rr, ak, cl;
      wv = ($urandom % 100) < 60;
      cm = ($urandom % 100) < 4;
      rr = ($urandom % 100) < 70;
      ak = ((m_npend > 0 && m_rptr == m_len[m_head]) && ($urandom % 2 == 0)) ||
           ($urandom % 200 == 0);
      cl = ($urandom % 1000) == 0;
      cyc(wv, 8'($urandom), cm, rr, ak, cl);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule